// File: doc/BRIEF.md
# AES Byte Substitution Unit, Forward and Inverse

This block substitutes four bytes of a 32-bit column at once. It computes either the AES forward S-box, used when encrypting, or the inverse S-box, used when decrypting. It uses no lookup ROM. Each byte lane contains one multiplicative-inverse circuit in GF(2^8), taken modulo x^8+x^4+x^3+x+1. The inversion runs in the tower field GF((2^4)^2): the byte is mapped linearly into the tower field, inverted there with GF(2^4) arithmetic, and mapped back.

The tower field has the form Y^2 + A·Y + B, with A = 1 and B = 9. Its GF(2^4) subfield is built on x^4+x+1. The encrypt path places the affine transform (constant 0x63) after the inversion. The decrypt path places the inverse affine transform (constant 0x05) before it. A single mode bit selects which affine stage sits in line, and the same mode bit applies to all lanes. The block is purely combinational and is meant to sit inside an iterative round datapath.

Top module: `aes_sub_word`

## Requirements
- R1: With mode_i = 0, every output byte is the forward S-box of its input byte: the inverse modulo 0x11B, then b_i = a_i ^ a_(i+4) ^ a_(i+5) ^ a_(i+6) ^ a_(i+7) ^ c_i with c = 0x63 and indices taken mod 8.
- R2: With mode_i = 1, every output byte is the inverse S-box of its input byte: first the inverse affine map with constant 0x05, then the inverse modulo 0x11B.
- R3: For every nonzero value fed to a lane's inversion stage, the product of that value and the stage's result, taken modulo 0x11B, is 0x01.
- R4: The inversion maps 0x00 to 0x00. So forward 0x00 gives 0x63, and inverse 0x63 gives 0x00.
- R5: Forward 0x53 gives 0xED, and inverse 0xED gives 0x53.
- R6: Byte lane k occupies bits 8k+7 down to 8k of both words. Each output lane depends only on its own input lane and on mode_i, and mode_i governs all lanes together.
- R7: For all 256 byte values, the inverse path applied to the forward output returns the original byte.
- R8: word_o follows word_i and mode_i with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 1 | 0 = forward substitution, 1 = inverse substitution |
| word_i | input | 32 | Four input bytes, lane k at bits 8k+7:8k |
| word_o | output | 32 | Four substituted bytes, same lane layout |

## Verification
The checker evaluates these properties on every input change:
- Each lane's inversion stage returns the true field inverse, or zero for a zero input.
- The fixed points that pin down the affine constants hold: 0x00 and 0x63, and 0x53 and 0xED.

Only the bench's scenarios can show the following:
- The full forward and inverse tables over all 256 values.
- That applying the forward path and then the inverse path returns every byte unchanged.
- That lanes do not leak into each other.
- That the output responds between clock edges.

// File: rtl/aes_sub_pkg.sv
package aes_sub_pkg;

  localparam int BYTE_W = 8;
  localparam logic [8:0] FIELD_POLY = 9'h11B;
  // tower field: Y^2 = A*Y + B with A = 1
  localparam logic [3:0] TOWER_B = 4'h9;
  localparam logic [7:0] FWD_CONST = 8'h63;
  localparam logic [7:0] INV_CONST = 8'h05;

  // GF(2^4) modulo x^4 + x + 1
  function automatic logic [3:0] gf16_mul(logic [3:0] a, logic [3:0] b);
    logic [3:0] acc;
    logic [3:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc ^= sh;
      sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'h3 : 4'h0);
    end
    return acc;
  endfunction

  function automatic logic [3:0] gf16_sq(logic [3:0] a);
    return gf16_mul(a, a);
  endfunction

  // a^14 = a^-1 for a != 0, and 0 -> 0
  function automatic logic [3:0] gf16_inv(logic [3:0] a);
    logic [3:0] p2, p3, p6, p12;
    p2  = gf16_sq(a);
    p3  = gf16_mul(p2, a);
    p6  = gf16_sq(p3);
    p12 = gf16_sq(p6);
    return gf16_mul(p12, p2);
  endfunction

  function automatic logic [7:0] tower_mul(logic [7:0] a, logic [7:0] b);
    logic [3:0] hh, hi, lo;
    hh = gf16_mul(a[7:4], b[7:4]);
    hi = hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]);
    lo = gf16_mul(a[3:0], b[3:0]) ^ gf16_mul(TOWER_B, hh);
    return {hi, lo};
  endfunction

  // column k of the matrix is the image of basis bit k
  function automatic logic [7:0] lin_map(logic [63:0] m, logic [7:0] a);
    logic [7:0] acc;
    acc = '0;
    for (int k = 0; k < 8; k++)
      if (a[k]) acc ^= m[k*8 +: 8];
    return acc;
  endfunction

  // first tower-field root of the byte-field polynomial
  function automatic logic [7:0] find_root();
    logic [7:0] cand, r, root;
    logic       found;
    root  = 8'h02;
    found = 1'b0;
    for (int c = 2; c < 256; c++) begin
      cand = 8'(c);
      r    = '0;
      for (int k = 8; k >= 0; k--)
        r = tower_mul(r, cand) ^ {7'd0, FIELD_POLY[k]};
      if (r == 8'h00 && !found) begin
        root  = cand;
        found = 1'b1;
      end
    end
    return root;
  endfunction

  function automatic logic [63:0] build_to_tower();
    logic [63:0] m;
    logic [7:0]  root, pw;
    root = find_root();
    pw   = 8'h01;
    m    = '0;
    for (int k = 0; k < 8; k++) begin
      m[k*8 +: 8] = pw;
      pw = tower_mul(pw, root);
    end
    return m;
  endfunction

  function automatic logic [63:0] build_from_tower(logic [63:0] fwd);
    logic [63:0] m;
    m = '0;
    for (int j = 0; j < 8; j++)
      for (int a = 0; a < 256; a++)
        if (lin_map(fwd, 8'(a)) == (8'h01 << j)) m[j*8 +: 8] = 8'(a);
    return m;
  endfunction

  localparam logic [63:0] TO_TOWER   = build_to_tower();
  localparam logic [63:0] FROM_TOWER = build_from_tower(TO_TOWER);

endpackage

// File: rtl/aes_fwd_affine.sv
module aes_fwd_affine
  import aes_sub_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  output logic [BYTE_W-1:0] b_o
);
  logic [7:0] r1, r2, r3, r4;

  assign r1  = {a_i[6:0], a_i[7]};
  assign r2  = {a_i[5:0], a_i[7:6]};
  assign r3  = {a_i[4:0], a_i[7:5]};
  assign r4  = {a_i[3:0], a_i[7:4]};
  assign b_o = a_i ^ r1 ^ r2 ^ r3 ^ r4 ^ FWD_CONST;
endmodule

// File: rtl/aes_inv_affine.sv
module aes_inv_affine
  import aes_sub_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  output logic [BYTE_W-1:0] b_o
);
  logic [7:0] r1, r3, r6;

  assign r1  = {a_i[6:0], a_i[7]};
  assign r3  = {a_i[4:0], a_i[7:5]};
  assign r6  = {a_i[1:0], a_i[7:2]};
  assign b_o = r1 ^ r3 ^ r6 ^ INV_CONST;
endmodule

// File: rtl/aes_gf_inv.sv
module aes_gf_inv
  import aes_sub_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  output logic [BYTE_W-1:0] inv_o
);
  logic [7:0] tw;
  logic [3:0] hi, lo, delta, dinv, n_hi, n_lo;

  always_comb begin
    tw    = lin_map(TO_TOWER, a_i);
    hi    = tw[7:4];
    lo    = tw[3:0];
    // norm: B*hi^2 + hi*lo + lo^2
    delta = gf16_mul(TOWER_B, gf16_sq(hi)) ^ gf16_mul(hi, lo) ^ gf16_sq(lo);
    dinv  = gf16_inv(delta);
    n_hi  = gf16_mul(hi, dinv);
    n_lo  = gf16_mul(hi ^ lo, dinv);
    inv_o = lin_map(FROM_TOWER, {n_hi, n_lo});
  end
endmodule

// File: rtl/aes_sub_word.sv
module aes_sub_word
  import aes_sub_pkg::*;
#(
  parameter int LANES = 4,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic              mode_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);
  logic [LANES-1:0][BYTE_W-1:0] in_b, pre_b, inv_in, inv_out, post_b, out_b;

  assign in_b = word_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    aes_inv_affine u_iaff (.a_i(in_b[g]),    .b_o(pre_b[g]));
    assign inv_in[g] = mode_i ? pre_b[g] : in_b[g];
    aes_gf_inv     u_inv  (.a_i(inv_in[g]),  .inv_o(inv_out[g]));
    aes_fwd_affine u_faff (.a_i(inv_out[g]), .b_o(post_b[g]));
    assign out_b[g] = mode_i ? inv_out[g] : post_b[g];
  end

  assign word_o = out_b;
endmodule

// File: rtl/aes_sub_word_chk.sv
module aes_sub_word_chk #(
  parameter int LANES = 4
) (
  input logic                  mode_i,
  input logic [LANES*8-1:0]    word_i,
  input logic [LANES*8-1:0]    word_o,
  input logic [LANES-1:0][7:0] inv_in,
  input logic [LANES-1:0][7:0] inv_out
);
  function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    logic [7:0] bi, bo;
    assign bi = word_i[g*8 +: 8];
    assign bo = word_o[g*8 +: 8];

    always_comb begin
      if (!$isunknown({inv_in[g], inv_out[g]})) begin
        if (inv_in[g] != 8'h00) begin
          p_inv_unit_r3: assert (ref_mul(inv_in[g], inv_out[g]) == 8'h01)
            else $error("inversion not unit");
        end else begin
          p_inv_zero_r4: assert (inv_out[g] == 8'h00)
            else $error("zero not kept");
        end
      end
      if (!$isunknown({mode_i, bi, bo})) begin
        if (!mode_i && bi == 8'h00) begin
          p_fwd_zero_r4: assert (bo == 8'h63) else $error("fwd 00");
        end
        if (mode_i && bi == 8'h63) begin
          p_inv_sixty3_r4: assert (bo == 8'h00) else $error("inv 63");
        end
        if (!mode_i && bi == 8'h53) begin
          p_fwd_53_r5: assert (bo == 8'hED) else $error("fwd 53");
        end
        if (mode_i && bi == 8'hED) begin
          p_inv_ed_r5: assert (bo == 8'h53) else $error("inv ED");
        end
      end
    end
  end
endmodule

bind aes_sub_word aes_sub_word_chk #(.LANES(LANES)) u_chk (
  .mode_i (mode_i),
  .word_i (word_i),
  .word_o (word_o),
  .inv_in (inv_in),
  .inv_out(inv_out)
);

// File: tb/tb_aes_sub_word.sv
module tb_aes_sub_word;
  logic        clk;
  logic        rst_ni;
  logic        mode;
  logic [31:0] win;
  logic [31:0] wout;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 0;
  logic [7:0]  ref_fwd [256];
  logic [7:0]  ref_inv [256];

  aes_sub_word dut (.mode_i(mode), .word_i(win), .word_o(wout));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {mode, input word, expected word}
  localparam logic [64:0] VECS [6] = '{
    {1'b0, 32'h00010253, 32'h637C77ED},
    {1'b0, 32'h10FF1180, 32'hCA1682CD},
    {1'b0, 32'h20202020, 32'hB7B7B7B7},
    {1'b1, 32'h637C77ED, 32'h00010253},
    {1'b1, 32'hCA1682CD, 32'h10FF1180},
    {1'b1, 32'h00000000, 32'h52525252}
  };

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc, sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1B : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [7:0] aff(logic [7:0] a);
    logic [7:0] b;
    for (int i = 0; i < 8; i++)
      b[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
    return b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [31:0] w);
    @(posedge clk);
    #1;
    mode = m;
    win  = w;
    @(negedge clk);
  endtask

  initial begin
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv;
      iv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (gmul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
      ref_fwd[x] = aff(iv);
    end
    for (int x = 0; x < 256; x++) ref_inv[ref_fwd[x]] = 8'(x);

    rst_ni = 1'b0;
    mode   = 1'b0;
    win    = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 reset-time output", wout, 32'h63636363);
    rst_ni = 1'b1;

    for (int v = 0; v < 6; v++) begin
      apply(VECS[v][64], VECS[v][63:32]);
      check(VECS[v][64] ? "R2 vector" : "R1 vector", wout, VECS[v][31:0]);
    end

    for (int v = 0; v < 64; v++) begin
      logic [31:0] w, e1, e2;
      w = {8'(v*4+3), 8'(v*4+2), 8'(v*4+1), 8'(v*4)};
      e1 = {ref_fwd[w[31:24]], ref_fwd[w[23:16]], ref_fwd[w[15:8]], ref_fwd[w[7:0]]};
      e2 = {ref_inv[w[31:24]], ref_inv[w[23:16]], ref_inv[w[15:8]], ref_inv[w[7:0]]};
      apply(1'b0, w);
      check("R1 forward sweep", wout, e1);
      apply(1'b1, w);
      check("R2 inverse sweep", wout, e2);
    end

    for (int x = 0; x < 256; x++) begin
      logic [31:0] y;
      apply(1'b0, {4{8'(x)}});
      y = wout;
      apply(1'b1, y);
      check("R7 round trip", wout, {4{8'(x)}});
    end

    for (int x = 1; x < 256; x++) begin
      apply(1'b1, {24'h0, aff(8'(x))});
      check("R3 inverse times input", {24'h0, gmul(wout[7:0], 8'(x))}, 32'h00000001);
    end

    apply(1'b1, 32'h63636363);
    check("R4 inverse of 63", wout, 32'h00000000);
    apply(1'b0, 32'h53535353);
    check("R5 forward 53", wout, 32'hEDEDEDED);
    apply(1'b1, 32'hEDEDEDED);
    check("R5 inverse ED", wout, 32'h53535353);

    for (int k = 0; k < 4; k++) begin
      logic [31:0] e;
      e = 32'h63636363;
      e[k*8 +: 8] = 8'hED;
      apply(1'b0, 32'h53 << (k*8));
      check("R6 lane isolation fwd", wout, e);
      e = 32'h52525252;
      e[k*8 +: 8] = 8'h53;
      apply(1'b1, 32'hED << (k*8));
      check("R6 lane isolation inv", wout, e);
    end

    @(negedge clk);
    mode = 1'b0;
    win  = 32'h00000053;
    #1;
    check("R8 no clock needed", wout, 32'h636363ED);
    mode = 1'b1;
    #1;
    check("R8 mode change mid-cycle", wout, 32'h52525200 | {24'h0, ref_inv[8'h53]});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule